// File: doc/BRIEF.md
# DMA Channel Trigger Action Controller

This block decides when one DMA channel may move data. It holds the channel's trigger and event configuration. It picks one peripheral request line by number, and it also takes a software trigger and an event input. Each accepted trigger releases a unit of work: a single beat, a whole block, or a whole transaction. The controller hands out that work one beat at a time. It does this through a one-cycle beat request strobe to a data mover, which answers with a beat completion pulse.

The controller walks through the beats of a block and the blocks of a transaction, using a beat count and a block count held steady on its inputs while the channel is enabled. A gated event input can turn into a trigger, make triggers conditional, suspend or resume the channel, or cancel the next end-of-block suspend. An optional output event pulse marks each completed block.

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset, `cfg_q` reads zero and `beat_req`, `suspended` and `evt_out` are low.
- R2: A configuration write updates the granularity, source, event action, event input enable and event output enable fields only while `ch_en` is low. The priority field updates on any write. `cfg_q` packs, from bit 0 upward: granularity [1:0], source [7:2], event action [10:8], event input enable [11], event output enable [12], priority [14:13].
- R3: Granularity code 0 makes one trigger release every beat of the current block.
- R4: Granularity code 2 makes one trigger release exactly one beat. Every beat request is a one-cycle strobe, and no new strobe is issued until the previous beat completes.
- R5: Granularity code 3 makes one trigger release all remaining beats of all blocks of the transaction, with no further trigger.
- R6: Granularity code 1 is reserved; with it no trigger produces any beat request.
- R7: Source value 0 ignores every peripheral line. Source value v, from 1 to the line count, selects peripheral line v-1. Larger values select no line.
- R8: A trigger that arrives while a granted unit is still running is held as pending. Only one pending trigger is kept, however many arrive.
- R9: The event input acts only when the event input enable bit is set. Otherwise an event has no effect.
- R10: Event action 4 (suspend) stops new beat requests once any beat in flight has completed, and sets `suspended`. Event action 5 (resume) clears `suspended` and lets pending work continue. No beat request is issued while `suspended` is high.
- R11: When `blk_end_susp` is high, the channel suspends at each block completion. Event action 6 sets a flag that cancels the next such suspend, and the flag then clears.
- R12: With event action 2, a peripheral trigger counts only if an event has been seen since the last counted peripheral trigger. With event action 3, a unit that starts at a block boundary waits until both a trigger and an event have been seen. Event action 1 turns each event into a trigger.
- R13: `evt_out` pulses for exactly one cycle at each block completion when event output enable is set, and never when it is clear.
- R14: Driving `ch_en` low clears all progress, pending triggers and suspend state, and forces the outputs low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | Channel enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_gran | input | 2 | Trigger granularity code to write |
| cfg_src | input | 6 | Peripheral source number to write |
| cfg_evact | input | 3 | Event action code to write |
| cfg_evie | input | 1 | Event input enable to write |
| cfg_evoe | input | 1 | Event output enable to write |
| cfg_lvl | input | 2 | Priority level to write |
| cfg_q | output | 15 | Current configuration, packed as in R2 |
| beats_per_block | input | 8 | Beats in each block (at least 1) |
| blocks_per_xfer | input | 8 | Blocks in each transaction (at least 1) |
| blk_end_susp | input | 1 | Suspend the channel at each block completion |
| periph_req | input | 39 | Peripheral trigger pulses |
| sw_trig | input | 1 | Software trigger pulse |
| evt_in | input | 1 | Incoming event pulse |
| beat_done | input | 1 | Data mover finished the requested beat |
| beat_req | output | 1 | One-cycle request to move one beat |
| suspended | output | 1 | Channel is suspended |
| evt_out | output | 1 | One-cycle pulse at block completion |

## Verification
The assertions take for granted that `beat_done` only arrives for a beat that was requested and not yet completed. They also assume that the beat and block counts are at least one and do not change while the channel is enabled. The bench keeps to both rules. Its data mover model answers each strobe exactly once after a random delay. It changes the counts only inside its setup step, with the channel disabled and long enough afterwards for any in-flight answer to drain. Triggers and events are single-cycle pulses driven on the falling edge, and each scenario starts from a fresh enable so that the beat and block positions begin at zero.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
  localparam int SRC_W = 6;

  typedef enum logic [1:0] {
    GR_BLOCK = 2'd0,
    GR_RSVD  = 2'd1,
    GR_BEAT  = 2'd2,
    GR_XFER  = 2'd3
  } gran_e;

  typedef enum logic [2:0] {
    EA_NONE   = 3'd0,
    EA_TRIG   = 3'd1,
    EA_CTRIG  = 3'd2,
    EA_CBLOCK = 3'd3,
    EA_SUSP   = 3'd4,
    EA_RESUME = 3'd5,
    EA_SKIP   = 3'd6,
    EA_RSVD   = 3'd7
  } evact_e;

  typedef struct packed {
    logic [1:0]       lvl;
    logic             evoe;
    logic             evie;
    evact_e           evact;
    logic [SRC_W-1:0] src;
    gran_e            gran;
  } cfg_t;
endpackage

// File: rtl/dma_trig_cfg.sv
module dma_trig_cfg
  import dma_trig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ch_en,
  input  logic wr,
  input  cfg_t wdata,
  output cfg_t q
);
  // Priority is always writable; everything else only while disabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr) begin
      q.lvl <= wdata.lvl;
      if (!ch_en) begin
        q.gran  <= wdata.gran;
        q.src   <= wdata.src;
        q.evact <= wdata.evact;
        q.evie  <= wdata.evie;
        q.evoe  <= wdata.evoe;
      end
    end
  end
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
  import dma_trig_pkg::*;
#(
  parameter int NUM_PERIPH = 39
) (
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic [SRC_W-1:0]      src,
  input  logic                  evt_in,
  input  logic                  evie,
  input  evact_e                evact,
  output logic                  periph_hit,
  output logic                  ev_trig,
  output logic                  ev_cond,
  output logic                  ev_susp,
  output logic                  ev_resume,
  output logic                  ev_skip,
  output logic                  ctrig_mode,
  output logic                  cblk_mode
);
  localparam int EXT_N = 2 ** SRC_W;

  // Source 0 and numbers past the last line map to a constant zero.
  logic [EXT_N-1:0] req_ext;
  assign req_ext[0] = 1'b0;
  for (genvar i = 1; i < EXT_N; i++) begin : g_ext
    if (i <= NUM_PERIPH) begin : g_line
      assign req_ext[i] = periph_req[i-1];
    end else begin : g_none
      assign req_ext[i] = 1'b0;
    end
  end
  assign periph_hit = req_ext[src];

  logic fire;
  always_comb begin
    fire       = evt_in & evie;
    ev_trig    = fire & (evact == EA_TRIG);
    ev_cond    = fire & ((evact == EA_CTRIG) | (evact == EA_CBLOCK));
    ev_susp    = fire & (evact == EA_SUSP);
    ev_resume  = fire & (evact == EA_RESUME);
    ev_skip    = fire & (evact == EA_SKIP);
    ctrig_mode = evie & (evact == EA_CTRIG);
    cblk_mode  = evie & (evact == EA_CBLOCK);
  end
endmodule

// File: rtl/dma_trig_seq.sv
module dma_trig_seq
  import dma_trig_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_en,
  input  gran_e             gran,
  input  logic              evoe,
  input  logic              ctrig_mode,
  input  logic              cblk_mode,
  input  logic              sw_trig,
  input  logic              periph_hit,
  input  logic              ev_trig,
  input  logic              ev_cond,
  input  logic              ev_susp,
  input  logic              ev_resume,
  input  logic              ev_skip,
  input  logic              blk_end_susp,
  input  logic [BEAT_W-1:0] beats_per_block,
  input  logic [BLK_W-1:0]  blocks_per_xfer,
  input  logic              beat_done,
  output logic              beat_req,
  output logic              suspended,
  output logic              evt_out
);
  logic running, outst, trig_pend, ev_pend, susp_req, skip_q;
  logic [BEAT_W-1:0] beat_idx;
  logic [BLK_W-1:0]  blk_idx;

  logic gran_ok, p_ok, ctrig_use, trig_in, at_blk_start, start, cblk_use;
  logic done_ok, last_beat, last_blk, blk_end, unit_end, issue;
  logic blk_susp, susp_take;

  always_comb begin
    gran_ok      = (gran != GR_RSVD);
    p_ok         = periph_hit & (~ctrig_mode | ev_pend);
    ctrig_use    = ctrig_mode & periph_hit & ev_pend;
    trig_in      = gran_ok & (sw_trig | p_ok | ev_trig);
    at_blk_start = (beat_idx == '0);
    start        = ~running & trig_pend & (~cblk_mode | ~at_blk_start | ev_pend);
    cblk_use     = start & cblk_mode & at_blk_start;
    done_ok      = beat_done & outst;
    last_beat    = (beat_idx == beats_per_block - 1'b1);
    last_blk     = (blk_idx == blocks_per_xfer - 1'b1);
    blk_end      = done_ok & last_beat;
    unique case (gran)
      GR_BEAT:  unit_end = 1'b1;
      GR_BLOCK: unit_end = last_beat;
      GR_XFER:  unit_end = last_beat & last_blk;
      default:  unit_end = 1'b1;
    endcase
    issue     = running & ~outst & ~suspended & ~susp_req;
    blk_susp  = blk_end & blk_end_susp & ~skip_q;
    susp_take = susp_req & (~outst | done_ok);
  end

  always_ff @(posedge clk) begin
    if (rst || !ch_en) begin
      running   <= 1'b0;
      outst     <= 1'b0;
      trig_pend <= 1'b0;
      ev_pend   <= 1'b0;
      susp_req  <= 1'b0;
      skip_q    <= 1'b0;
      suspended <= 1'b0;
      beat_req  <= 1'b0;
      evt_out   <= 1'b0;
      beat_idx  <= '0;
      blk_idx   <= '0;
    end else begin
      beat_req  <= issue;
      outst     <= issue | (outst & ~done_ok);
      trig_pend <= (trig_pend & ~start) | trig_in;
      running   <= start | (running & ~(done_ok & unit_end));
      ev_pend   <= (ev_pend & ~(ctrig_use | cblk_use)) | ev_cond;
      evt_out   <= blk_end & evoe;
      if (done_ok) begin
        beat_idx <= last_beat ? '0 : beat_idx + 1'b1;
        if (last_beat) blk_idx <= last_blk ? '0 : blk_idx + 1'b1;
      end
      if (ev_resume) begin
        suspended <= 1'b0;
        susp_req  <= 1'b0;
      end else begin
        suspended <= suspended | susp_take | blk_susp;
        susp_req  <= (susp_req & ~susp_take) | ev_susp;
      end
      if (ev_skip) skip_q <= 1'b1;
      else if (blk_end & blk_end_susp) skip_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
  import dma_trig_pkg::*;
#(
  parameter int NUM_PERIPH = 39,
  parameter int BEAT_W     = 8,
  parameter int BLK_W      = 8,
  localparam int CFG_W     = $bits(cfg_t)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ch_en,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_gran,
  input  logic [SRC_W-1:0]      cfg_src,
  input  logic [2:0]            cfg_evact,
  input  logic                  cfg_evie,
  input  logic                  cfg_evoe,
  input  logic [1:0]            cfg_lvl,
  output logic [CFG_W-1:0]      cfg_q,
  input  logic [BEAT_W-1:0]     beats_per_block,
  input  logic [BLK_W-1:0]      blocks_per_xfer,
  input  logic                  blk_end_susp,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic                  sw_trig,
  input  logic                  evt_in,
  input  logic                  beat_done,
  output logic                  beat_req,
  output logic                  suspended,
  output logic                  evt_out
);
  cfg_t wdata, cfg;

  always_comb begin
    wdata.lvl   = cfg_lvl;
    wdata.evoe  = cfg_evoe;
    wdata.evie  = cfg_evie;
    wdata.evact = evact_e'(cfg_evact);
    wdata.src   = cfg_src;
    wdata.gran  = gran_e'(cfg_gran);
  end

  dma_trig_cfg u_cfg (
    .clk(clk), .rst(rst), .ch_en(ch_en), .wr(cfg_wr), .wdata(wdata), .q(cfg)
  );
  assign cfg_q = cfg;

  logic periph_hit, ev_trig, ev_cond, ev_susp, ev_resume, ev_skip;
  logic ctrig_mode, cblk_mode;

  dma_trig_sel #(.NUM_PERIPH(NUM_PERIPH)) u_sel (
    .periph_req(periph_req), .src(cfg.src), .evt_in(evt_in),
    .evie(cfg.evie), .evact(cfg.evact),
    .periph_hit(periph_hit), .ev_trig(ev_trig), .ev_cond(ev_cond),
    .ev_susp(ev_susp), .ev_resume(ev_resume), .ev_skip(ev_skip),
    .ctrig_mode(ctrig_mode), .cblk_mode(cblk_mode)
  );

  dma_trig_seq #(.BEAT_W(BEAT_W), .BLK_W(BLK_W)) u_seq (
    .clk(clk), .rst(rst), .ch_en(ch_en), .gran(cfg.gran), .evoe(cfg.evoe),
    .ctrig_mode(ctrig_mode), .cblk_mode(cblk_mode),
    .sw_trig(sw_trig), .periph_hit(periph_hit), .ev_trig(ev_trig),
    .ev_cond(ev_cond), .ev_susp(ev_susp), .ev_resume(ev_resume),
    .ev_skip(ev_skip), .blk_end_susp(blk_end_susp),
    .beats_per_block(beats_per_block), .blocks_per_xfer(blocks_per_xfer),
    .beat_done(beat_done), .beat_req(beat_req), .suspended(suspended),
    .evt_out(evt_out)
  );
endmodule

// File: rtl/dma_trig_ctrl_chk.sv
module dma_trig_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        ch_en,
  input logic [12:0] lock_q,
  input logic        beat_req,
  input logic        suspended,
  input logic        evt_out
);
  a_r2_locked_fields: assert property (@(posedge clk) disable iff (rst)
    ch_en |=> $stable(lock_q));

  a_r4_beat_strobe: assert property (@(posedge clk) disable iff (rst)
    beat_req |=> !beat_req);

  a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (lock_q[1:0] == 2'd1) |-> !beat_req);

  a_r10_no_req_suspended: assert property (@(posedge clk) disable iff (rst)
    beat_req |-> !suspended);

  a_r13_evt_needs_enable: assert property (@(posedge clk) disable iff (rst)
    evt_out |-> lock_q[12]);

  a_r13_evt_single: assert property (@(posedge clk) disable iff (rst)
    evt_out |=> !evt_out);

  a_r14_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !ch_en |=> (!beat_req && !suspended && !evt_out));
endmodule

bind dma_trig_ctrl dma_trig_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ch_en(ch_en), .lock_q(cfg_q[12:0]),
  .beat_req(beat_req), .suspended(suspended), .evt_out(evt_out)
);

// File: tb/tb_dma_trig_ctrl.sv
module tb_dma_trig_ctrl;
  localparam int NP = 39;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, ch_en = 1'b0, cfg_wr = 1'b0;
  logic [1:0] cfg_gran = '0, cfg_lvl = '0;
  logic [5:0] cfg_src = '0;
  logic [2:0] cfg_evact = '0;
  logic cfg_evie = 1'b0, cfg_evoe = 1'b0;
  logic [14:0] cfg_q;
  logic [7:0] beats_per_block = 8'd1, blocks_per_xfer = 8'd1;
  logic blk_end_susp = 1'b0;
  logic [NP-1:0] periph_req = '0;
  logic sw_trig = 1'b0, evt_in = 1'b0, beat_done;
  logic beat_req, suspended, evt_out;

  dma_trig_ctrl dut (
    .clk(clk), .rst(rst), .ch_en(ch_en), .cfg_wr(cfg_wr), .cfg_gran(cfg_gran),
    .cfg_src(cfg_src), .cfg_evact(cfg_evact), .cfg_evie(cfg_evie),
    .cfg_evoe(cfg_evoe), .cfg_lvl(cfg_lvl), .cfg_q(cfg_q),
    .beats_per_block(beats_per_block), .blocks_per_xfer(blocks_per_xfer),
    .blk_end_susp(blk_end_susp), .periph_req(periph_req), .sw_trig(sw_trig),
    .evt_in(evt_in), .beat_done(beat_done), .beat_req(beat_req),
    .suspended(suspended), .evt_out(evt_out)
  );

  int tests = 0, fails = 0;
  int beats_seen = 0, evts_seen = 0, evt_long = 0;
  int mdly = 1, mv_cnt = 0;
  logic mv_busy, evt_prev;

  // Data mover model: answers each strobe once after mdly cycles.
  always @(negedge clk) begin
    if (rst) begin
      beat_done <= 1'b0; mv_busy <= 1'b0; evt_prev <= 1'b0;
    end else begin
      beat_done <= 1'b0;
      if (beat_req) begin
        beats_seen <= beats_seen + 1; mv_busy <= 1'b1; mv_cnt <= mdly;
      end else if (mv_busy) begin
        if (mv_cnt == 0) begin beat_done <= 1'b1; mv_busy <= 1'b0; end
        else mv_cnt <= mv_cnt - 1;
      end
      if (evt_out) evts_seen <= evts_seen + 1;
      if (evt_out && evt_prev) evt_long <= evt_long + 1;
      evt_prev <= evt_out;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_beats(int g, int bpb, int bpt);
    case (g)
      0: return bpb;
      2: return 1;
      3: return bpb * bpt;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_blocks(int g, int bpb, int bpt);
    case (g)
      0: return 1;
      2: return (bpb == 1) ? 1 : 0;
      3: return bpt;
      default: return 0;
    endcase
  endfunction

  function automatic int pack(int g, int s, int ea, int ie, int oe, int lv);
    return (lv << 13) | (oe << 12) | (ie << 11) | (ea << 8) | (s << 2) | g;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(int g, int s, int ea, int ie, int oe, int bpb, int bpt, int bes);
    ch_en = 1'b0;
    cyc(12);
    cfg_gran = 2'(g); cfg_src = 6'(s); cfg_evact = 3'(ea);
    cfg_evie = ie[0]; cfg_evoe = oe[0]; cfg_lvl = 2'd0;
    cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
    beats_per_block = 8'(bpb); blocks_per_xfer = 8'(bpt); blk_end_susp = bes[0];
    ch_en = 1'b1; cyc(1);
  endtask

  task automatic pulse_sw();
    sw_trig = 1'b1; cyc(1); sw_trig = 1'b0;
  endtask
  task automatic pulse_ev();
    evt_in = 1'b1; cyc(1); evt_in = 1'b0;
  endtask
  task automatic pulse_p(int i);
    periph_req[i] = 1'b1; cyc(1); periph_req = '0;
  endtask
  task automatic pulse_all();
    periph_req = '1; cyc(1); periph_req = '0;
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b0, b1, e0;
    void'($urandom(32'd2024));
    cyc(4); rst = 1'b0; cyc(2);

    // R1: reset state
    chk("R1 cfg_q", int'(cfg_q), 0);
    chk("R1 beat_req", int'(beat_req), 0);
    chk("R1 suspended", int'(suspended), 0);
    chk("R1 evt_out", int'(evt_out), 0);

    // R2: enable protection, priority always writable
    setup(2, 3, 1, 1, 1, 1, 1, 0);
    chk("R2 write while disabled", int'(cfg_q), pack(2, 3, 1, 1, 1, 0));
    cfg_gran = 2'd0; cfg_src = 6'd9; cfg_evact = 3'd4; cfg_evie = 1'b0;
    cfg_evoe = 1'b0; cfg_lvl = 2'd3;
    cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0; cyc(1);
    chk("R2 write while enabled", int'(cfg_q), pack(2, 3, 1, 1, 1, 3));

    // R7: source selection
    mdly = 1;
    setup(2, 5, 0, 0, 0, 1, 1, 0);
    b0 = beats_seen; pulse_p(4); cyc(30);
    chk("R7 selected line", beats_seen - b0, 1);
    b0 = beats_seen; pulse_p(3); cyc(30);
    chk("R7 other line ignored", beats_seen - b0, 0);
    setup(2, 39, 0, 0, 0, 1, 1, 0);
    b0 = beats_seen; pulse_p(38); cyc(30);
    chk("R7 last line", beats_seen - b0, 1);
    setup(2, 0, 0, 0, 0, 1, 1, 0);
    b0 = beats_seen; pulse_all(); cyc(30);
    chk("R7 source zero", beats_seen - b0, 0);
    setup(2, 50, 0, 0, 0, 1, 1, 0);
    b0 = beats_seen; pulse_all(); cyc(30);
    chk("R7 source past lines", beats_seen - b0, 0);

    // R8: one pending trigger at most
    mdly = 3;
    setup(0, 0, 0, 0, 0, 4, 1, 0);
    b0 = beats_seen;
    pulse_sw(); cyc(3); pulse_sw(); cyc(3); pulse_sw(); cyc(3); pulse_sw();
    cyc(150);
    chk("R8 two blocks only", beats_seen - b0, 8);

    // R9: event enable gates the event
    mdly = 1;
    setup(2, 0, 1, 0, 0, 1, 1, 0);
    b0 = beats_seen; pulse_ev(); cyc(30);
    chk("R9 event ignored", beats_seen - b0, 0);
    setup(2, 0, 1, 1, 0, 1, 1, 0);
    b0 = beats_seen; pulse_ev(); cyc(30);
    chk("R12 event as trigger", beats_seen - b0, 1);

    // R10: suspend event mid transaction
    mdly = 2;
    setup(3, 0, 4, 1, 0, 4, 2, 0);
    b0 = beats_seen; pulse_sw(); cyc(8); pulse_ev(); cyc(30);
    chk("R10 suspended set", int'(suspended), 1);
    b1 = beats_seen; cyc(40);
    chk("R10 beats frozen", beats_seen - b1, 0);
    chk("R10 stopped early", int'((beats_seen - b0) < 8), 1);

    // R10: resume after block-end suspend
    setup(0, 0, 5, 1, 0, 2, 1, 1);
    b0 = beats_seen; pulse_sw(); cyc(60);
    chk("R10 first block", beats_seen - b0, 2);
    chk("R11 block-end suspend", int'(suspended), 1);
    pulse_sw(); cyc(40);
    chk("R10 no beats while suspended", beats_seen - b0, 2);
    pulse_ev(); cyc(60);
    chk("R10 resume releases block", beats_seen - b0, 4);

    // R11: skip the next block-end suspend once
    setup(0, 0, 6, 1, 0, 2, 1, 1);
    b0 = beats_seen; pulse_ev(); pulse_sw(); cyc(60);
    chk("R11 skip beats", beats_seen - b0, 2);
    chk("R11 suspend skipped", int'(suspended), 0);
    pulse_sw(); cyc(60);
    chk("R11 second block beats", beats_seen - b0, 4);
    chk("R11 skip cleared", int'(suspended), 1);

    // R12: conditional peripheral trigger
    mdly = 1;
    setup(2, 1, 2, 1, 0, 1, 1, 0);
    b0 = beats_seen; pulse_p(0); cyc(30);
    chk("R12 ctrig no event", beats_seen - b0, 0);
    pulse_ev(); cyc(2); pulse_p(0); cyc(30);
    chk("R12 ctrig with event", beats_seen - b0, 1);
    pulse_p(0); cyc(30);
    chk("R12 ctrig event consumed", beats_seen - b0, 1);

    // R12: conditional block
    setup(0, 0, 3, 1, 0, 2, 1, 0);
    b0 = beats_seen; pulse_sw(); cyc(40);
    chk("R12 cblock waits", beats_seen - b0, 0);
    pulse_ev(); cyc(60);
    chk("R12 cblock runs", beats_seen - b0, 2);

    // R13: output event pulse
    setup(0, 0, 0, 0, 1, 3, 1, 0);
    e0 = evts_seen; pulse_sw(); cyc(60);
    chk("R13 one pulse", evts_seen - e0, 1);
    chk("R13 pulse width", evt_long, 0);
    setup(0, 0, 0, 0, 0, 3, 1, 0);
    e0 = evts_seen; pulse_sw(); cyc(60);
    chk("R13 disabled output", evts_seen - e0, 0);

    // R14: disable clears progress
    mdly = 2;
    setup(3, 0, 0, 0, 0, 4, 3, 0);
    pulse_sw(); cyc(10);
    ch_en = 1'b0; cyc(2);
    chk("R14 beat_req low", int'(beat_req), 0);
    chk("R14 suspended low", int'(suspended), 0);
    setup(3, 0, 0, 0, 0, 4, 3, 0);
    b0 = beats_seen; pulse_sw(); cyc(150);
    chk("R14 full run after re-enable", beats_seen - b0, 12);

    // R3 R4 R5 R6: random granularity runs
    for (int it = 0; it < 40; it++) begin
      int g, bpb, bpt, oe;
      string tag;
      g   = int'($urandom_range(0, 3));
      bpb = int'($urandom_range(1, 4));
      bpt = int'($urandom_range(1, 3));
      oe  = int'($urandom_range(0, 1));
      mdly = int'($urandom_range(0, 3));
      tag = (g == 0) ? "R3" : (g == 1) ? "R6" : (g == 2) ? "R4" : "R5";
      setup(g, 0, 0, 0, oe, bpb, bpt, 0);
      b0 = beats_seen; e0 = evts_seen;
      pulse_sw(); cyc(150);
      chk({tag, " beats"}, beats_seen - b0, exp_beats(g, bpb, bpt));
      chk({tag, " R13 events"}, evts_seen - e0, (oe == 1) ? exp_blocks(g, bpb, bpt) : 0);
    end
    chk("R13 pulse width random", evt_long, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule